// File: doc/BRIEF.md
# GPIO Port Register File

This block is the software-visible register file of a 32-pin general purpose I/O port. A processor reaches it over a simple 32-bit register bus that only carries whole, word-aligned words, with little-endian data. It holds three kinds of state:

- an output latch;
- a direction latch;
- one 32-bit configuration word per pin.

The output latch and the direction latch each have three write addresses. One replaces the latch, one sets bits and one clears bits, so a single bus write can change some pins without a read-modify-write sequence.

The direction of pin n exists in two places: bit n of the direction latch and bit 0 of pin n's configuration word. Both places read back as the same bit. Every write path that changes one of them changes the other.

The latched values go out on flat vectors to a per-pin resolution block, which drives the pads. That block returns a resolved input word, and the register file samples it every cycle and returns it on reads. The bus has no back-pressure. A request is accepted in the cycle it is presented, and a read answers with a valid pulse one cycle later.

Top module: `gpio_port_regs`

## Requirements
- R1: A write to offset 0x504 loads the whole output latch with the write data; the new value appears on `pin_out` in the cycle after the write.
- R2: A write to 0x508 sets every output latch bit that is 1 in the write data. A write to 0x50C clears every output latch bit that is 1 in the write data. Bits that are 0 in the write data keep their value in both cases.
- R3: Reads from any of 0x504, 0x508 or 0x50C return the current output latch.
- R4: Writes to 0x514, 0x518 and 0x51C load, set and clear the direction latch with the same rules as R1 and R2. Reads from any of these three offsets return the direction latch.
- R5: After any write to a direction-latch offset, bit 0 of each pin's configuration word equals that pin's direction bit. Bits 31..1 of every configuration word are unchanged.
- R6: The configuration word of pin n sits at offset 0x700 + 4*n, for n from 0 to 31. A write there stores the whole word, and its bit 0 becomes bit n of the direction latch. A read returns the stored word.
- R7: Reset does the following:
  - clears the output latch, the direction latch and the sampled input word;
  - sets every configuration word to 0x00000002;
  - holds `bus_rvalid`, `bus_rdata` and `bus_err` at 0.
- R8: A read from offset 0x510 returns the value `pin_in` held at the clock edge before the edge that accepts the read.
- R9: A read from an unmapped offset returns zero data with `bus_err` high for the single cycle of its `bus_rvalid` pulse. An offset is unmapped if its two low bits are non-zero or it lies outside all of the offsets above. A mapped read returns `bus_err` low.
- R10: A write to an unmapped offset, or to the read-only offset 0x510, changes no state.
- R11: Every read request accepted on a clock edge raises `bus_rvalid` for exactly the following cycle, with its data and error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Bus request, accepted on every rising edge where it is high |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read response valid, one cycle after a read request |
| bus_rdata | output | 32 | Read data, zero when no response or on error |
| bus_err | output | 1 | Read of an unmapped offset, high together with bus_rvalid |
| pin_in | input | 32 | Resolved input word from the pin resolution logic |
| pin_out | output | 32 | Output latch |
| pin_dir | output | 32 | Direction latch, 1 = output |
| pin_cfg | output | 1024 | Configuration words, pin n at bits 32*n+31..32*n |

## Verification
Timing of each result:
- A write is accepted on a rising edge, and the latches, the direction mirror and `pin_cfg` all show the new state right after that same edge.
- A read is accepted on a rising edge and answers with `bus_rvalid`, data and error flag right after that edge.
- The sampled input adds one more register, so a read of the input offset returns `pin_in` as it stood one edge before the accepting edge.

The bench drives every request at a falling edge and samples at the next falling edge, which falls between the accepting edge and the following edge. For input reads, it changes `pin_in` at least one rising edge before the read request is driven.

// File: rtl/gpio_regs_pkg.sv
package gpio_regs_pkg;

  // Byte offsets within the port window
  localparam int unsigned OFS_OUT     = 32'h504;
  localparam int unsigned OFS_OUT_SET = 32'h508;
  localparam int unsigned OFS_OUT_CLR = 32'h50C;
  localparam int unsigned OFS_IN      = 32'h510;
  localparam int unsigned OFS_DIR     = 32'h514;
  localparam int unsigned OFS_DIR_SET = 32'h518;
  localparam int unsigned OFS_DIR_CLR = 32'h51C;
  localparam int unsigned OFS_CFG     = 32'h700;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_OUT,
    SEL_OUT_SET,
    SEL_OUT_CLR,
    SEL_IN,
    SEL_DIR,
    SEL_DIR_SET,
    SEL_DIR_CLR,
    SEL_CFG
  } reg_sel_e;

  typedef enum logic [1:0] {
    OP_LOAD,
    OP_SET,
    OP_CLR
  } latch_op_e;

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_regs_pkg::*;
#(
  parameter int AW    = 12,
  parameter int NPINS = 32,
  localparam int PIDX_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic [AW-1:0]     addr,
  output reg_sel_e          sel,
  output logic [PIDX_W-1:0] pin_idx
);

  localparam logic [AW-1:0] A_OUT     = AW'(OFS_OUT);
  localparam logic [AW-1:0] A_OUT_SET = AW'(OFS_OUT_SET);
  localparam logic [AW-1:0] A_OUT_CLR = AW'(OFS_OUT_CLR);
  localparam logic [AW-1:0] A_IN      = AW'(OFS_IN);
  localparam logic [AW-1:0] A_DIR     = AW'(OFS_DIR);
  localparam logic [AW-1:0] A_DIR_SET = AW'(OFS_DIR_SET);
  localparam logic [AW-1:0] A_DIR_CLR = AW'(OFS_DIR_CLR);
  localparam logic [AW-1:0] CFG_LO    = AW'(OFS_CFG);
  localparam logic [AW:0]   CFG_HI    = (AW+1)'(OFS_CFG + 4 * NPINS);

  always_comb begin
    sel     = SEL_NONE;
    pin_idx = '0;
    if (addr[1:0] == 2'b00) begin
      if      (addr == A_OUT)     sel = SEL_OUT;
      else if (addr == A_OUT_SET) sel = SEL_OUT_SET;
      else if (addr == A_OUT_CLR) sel = SEL_OUT_CLR;
      else if (addr == A_IN)      sel = SEL_IN;
      else if (addr == A_DIR)     sel = SEL_DIR;
      else if (addr == A_DIR_SET) sel = SEL_DIR_SET;
      else if (addr == A_DIR_CLR) sel = SEL_DIR_CLR;
      else if (addr >= CFG_LO && {1'b0, addr} < CFG_HI) begin
        sel     = SEL_CFG;
        pin_idx = PIDX_W'((addr - CFG_LO) >> 2);
      end
    end
  end

endmodule

// File: rtl/gpio_latch_bank.sv
module gpio_latch_bank
  import gpio_regs_pkg::*;
#(
  parameter int W = 32,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  latch_op_e     op,
  input  logic [W-1:0]  wdata,
  input  logic          bit_we,
  input  logic [IW-1:0] bit_idx,
  input  logic          bit_val,
  output logic [W-1:0]  q
);

  logic [W-1:0] nxt;

  always_comb begin
    nxt = q;
    if (wr_en) begin
      case (op)
        OP_LOAD: nxt = wdata;
        OP_SET:  nxt = q | wdata;
        OP_CLR:  nxt = q & ~wdata;
        default: nxt = q;
      endcase
    end
    if (bit_we) nxt[bit_idx] = bit_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  AST_LOAD_REPLACES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op == OP_LOAD && !bit_we) |=> q == $past(wdata)); // R1
  AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op == OP_SET && !bit_we) |=> (q & $past(wdata)) == $past(wdata)); // R2
  AST_CLR_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op == OP_CLR && !bit_we) |=> (q & $past(wdata)) == '0); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !bit_we) |=> $stable(q)); // R10

endmodule

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank #(
  parameter int NPINS = 32,
  parameter int DW    = 32,
  parameter logic [DW-1:0] CFG_RST = DW'(2),
  localparam int PIDX_W = (NPINS > 1) ? $clog2(NPINS) : 1,
  localparam int HW     = DW - 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [PIDX_W-1:0]   wr_idx,
  input  logic [HW-1:0]       wdata_hi,
  output logic [NPINS*HW-1:0] cfg_hi_flat
);

  // Bits DW-1..1 of each word; bit 0 lives in the direction latch.
  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic [HW-1:0] word_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   word_q <= CFG_RST[DW-1:1];
      else if (wr_en && wr_idx == PIDX_W'(p))        word_q <= wdata_hi;
    end

    assign cfg_hi_flat[p*HW +: HW] = word_q;
  end

  AST_CFG_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_hi_flat)); // R10

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_regs_pkg::*;
#(
  parameter int AW    = 12,
  parameter int DW    = 32,
  parameter int NPINS = 32,
  localparam int PIDX_W = (NPINS > 1) ? $clog2(NPINS) : 1,
  localparam int HW     = DW - 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_req,
  input  logic                bus_we,
  input  logic [AW-1:0]       bus_addr,
  input  logic [DW-1:0]       bus_wdata,
  output logic                bus_rvalid,
  output logic [DW-1:0]       bus_rdata,
  output logic                bus_err,
  input  logic [NPINS-1:0]    pin_in,
  output logic [NPINS-1:0]    pin_out,
  output logic [NPINS-1:0]    pin_dir,
  output logic [NPINS*DW-1:0] pin_cfg
);

  reg_sel_e            sel;
  logic [PIDX_W-1:0]   pin_idx;
  logic                wr, rd;
  logic                out_wr, dir_wr, cfg_wr;
  latch_op_e           out_op, dir_op;
  logic [NPINS*HW-1:0] cfg_hi_flat;
  logic [NPINS-1:0]    in_q;
  logic [DW-1:0]       rd_word;
  logic                rd_hit;

  assign wr = bus_req &  bus_we;
  assign rd = bus_req & ~bus_we;

  gpio_addr_decode #(.AW(AW), .NPINS(NPINS)) u_dec (
    .addr    (bus_addr),
    .sel     (sel),
    .pin_idx (pin_idx)
  );

  always_comb begin
    out_wr = 1'b0;
    dir_wr = 1'b0;
    out_op = OP_LOAD;
    dir_op = OP_LOAD;
    cfg_wr = wr && (sel == SEL_CFG);
    case (sel)
      SEL_OUT:     begin out_wr = wr; out_op = OP_LOAD; end
      SEL_OUT_SET: begin out_wr = wr; out_op = OP_SET;  end
      SEL_OUT_CLR: begin out_wr = wr; out_op = OP_CLR;  end
      SEL_DIR:     begin dir_wr = wr; dir_op = OP_LOAD; end
      SEL_DIR_SET: begin dir_wr = wr; dir_op = OP_SET;  end
      SEL_DIR_CLR: begin dir_wr = wr; dir_op = OP_CLR;  end
      default: ;
    endcase
  end

  gpio_latch_bank #(.W(NPINS)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (out_wr),
    .op      (out_op),
    .wdata   (bus_wdata[NPINS-1:0]),
    .bit_we  (1'b0),
    .bit_idx ('0),
    .bit_val (1'b0),
    .q       (pin_out)
  );

  // Direction latch: port-wide writes plus single-bit loads from config writes
  gpio_latch_bank #(.W(NPINS)) u_dir (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (dir_wr),
    .op      (dir_op),
    .wdata   (bus_wdata[NPINS-1:0]),
    .bit_we  (cfg_wr),
    .bit_idx (pin_idx),
    .bit_val (bus_wdata[0]),
    .q       (pin_dir)
  );

  gpio_cfg_bank #(.NPINS(NPINS), .DW(DW)) u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (cfg_wr),
    .wr_idx      (pin_idx),
    .wdata_hi    (bus_wdata[DW-1:1]),
    .cfg_hi_flat (cfg_hi_flat)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_cfg_out
    assign pin_cfg[p*DW +: DW] = {cfg_hi_flat[p*HW +: HW], pin_dir[p]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_q <= '0;
    else        in_q <= pin_in;
  end

  always_comb begin
    rd_hit  = 1'b1;
    rd_word = '0;
    case (sel)
      SEL_OUT, SEL_OUT_SET, SEL_OUT_CLR: rd_word = DW'(pin_out);
      SEL_DIR, SEL_DIR_SET, SEL_DIR_CLR: rd_word = DW'(pin_dir);
      SEL_IN:  rd_word = DW'(in_q);
      SEL_CFG: rd_word = {cfg_hi_flat[int'(pin_idx)*HW +: HW], pin_dir[pin_idx]};
      default: rd_hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
      bus_err    <= 1'b0;
    end else begin
      bus_rvalid <= rd;
      bus_rdata  <= (rd && rd_hit) ? rd_word : '0;
      bus_err    <= rd && !rd_hit;
    end
  end

  AST_READ_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> bus_rvalid); // R11
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !bus_rvalid); // R11
  AST_ERR_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> bus_rvalid); // R9
  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> bus_rdata == '0); // R9
  AST_CFG_BIT0_TO_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> pin_dir[$past(pin_idx)] == $past(bus_wdata[0])); // R6
  AST_IN_SAMPLED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && sel == SEL_IN) |=> bus_rdata == DW'($past(in_q))); // R8

endmodule

// File: tb/gpio_port_regs_tb.sv
`timescale 1ns/1ps
module gpio_port_regs_tb;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_req = 1'b0;
  logic          bus_we = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic          bus_rvalid;
  logic [31:0]   bus_rdata;
  logic          bus_err;
  logic [31:0]   pin_in = '0;
  logic [31:0]   pin_out;
  logic [31:0]   pin_dir;
  logic [1023:0] pin_cfg;

  int n_chk = 0;
  int n_fail = 0;

  logic [31:0] m_out, m_dir, m_in;
  logic [31:0] m_cfg [32];

  always #2 clk = ~clk;

  gpio_port_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .pin_in(pin_in),
    .pin_out(pin_out), .pin_dir(pin_dir), .pin_cfg(pin_cfg)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  function automatic bit is_cfg(input logic [11:0] a);
    return a[1:0] == 2'b00 && a >= 12'h700 && a <= 12'h77C;
  endfunction

  task automatic model_write(input logic [11:0] a, input logic [31:0] d);
    bit dir_touched = 1'b0;
    case (a)
      12'h504: m_out = d;
      12'h508: m_out = m_out | d;
      12'h50C: m_out = m_out & ~d;
      12'h514: begin m_dir = d;           dir_touched = 1'b1; end
      12'h518: begin m_dir = m_dir | d;   dir_touched = 1'b1; end
      12'h51C: begin m_dir = m_dir & ~d;  dir_touched = 1'b1; end
      default: if (is_cfg(a)) begin
        m_cfg[(a - 12'h700) >> 2] = d;
        m_dir[(a - 12'h700) >> 2] = d[0];
      end
    endcase
    if (dir_touched)
      for (int p = 0; p < 32; p++) m_cfg[p][0] = m_dir[p];
  endtask

  task automatic model_read(input logic [11:0] a, output bit hit, output logic [31:0] v);
    hit = 1'b1;
    case (a)
      12'h504, 12'h508, 12'h50C: v = m_out;
      12'h514, 12'h518, 12'h51C: v = m_dir;
      12'h510: v = m_in;
      default: if (is_cfg(a)) v = m_cfg[(a - 12'h700) >> 2];
               else begin hit = 1'b0; v = '0; end
    endcase
  endtask

  task automatic check_state(input string t_main, input string t_cfg);
    chk({t_main, " pin_out"}, pin_out, m_out);
    chk({t_main, " pin_dir"}, pin_dir, m_dir);
    for (int p = 0; p < 32; p++) chk({t_cfg, " pin_cfg"}, pin_cfg[p*32 +: 32], m_cfg[p]);
  endtask

  task automatic do_write(input logic [11:0] a, input logic [31:0] d,
                          input string t_main, input string t_cfg);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
    model_write(a, d);
    check_state(t_main, t_cfg);
  endtask

  task automatic do_read(input logic [11:0] a, input string tag);
    bit hit;
    logic [31:0] v;
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
    model_read(a, hit, v);
    chk({tag, " R11 rvalid"}, {31'b0, bus_rvalid}, 32'd1);
    chk({tag, " rdata"}, bus_rdata, v);
    chk({tag, " R9 err"}, {31'b0, bus_err}, {31'b0, ~hit});
  endtask

  function automatic logic [11:0] pick_addr(input int k);
    case (k)
      0: return 12'h504;  1: return 12'h508;  2: return 12'h50C;
      3: return 12'h510;  4: return 12'h514;  5: return 12'h518;
      6: return 12'h51C;
      7, 8: return 12'h700 + 12'($urandom_range(0, 31) * 4);
      default: case ($urandom_range(0, 5))
        0: return 12'h500;  1: return 12'h505;  2: return 12'h780;
        3: return 12'h6FC;  4: return 12'h702;  default: return 12'hFFC;
      endcase
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    m_out = '0; m_dir = '0; m_in = '0;
    for (int p = 0; p < 32; p++) m_cfg[p] = 32'h2;
    repeat (3) @(negedge clk);
    // R7: reset state
    check_state("R7", "R7");
    chk("R7 rvalid", {31'b0, bus_rvalid}, 32'd0);
    chk("R7 rdata", bus_rdata, 32'd0);
    chk("R7 err", {31'b0, bus_err}, 32'd0);
    rst_n = 1'b1;
    do_read(12'h510, "R7 R8 input after reset");
    do_read(12'h700, "R7 cfg0 reset");
    do_read(12'h77C, "R7 cfg31 reset");

    // R1 R2 R3
    do_write(12'h504, 32'hA5A5_0F0F, "R1", "R1");
    do_write(12'h508, 32'h0000_F000, "R2", "R2");
    do_write(12'h50C, 32'h0000_0F01, "R2", "R2");
    do_read(12'h504, "R3 via load offset");
    do_read(12'h508, "R3 via set offset");
    do_read(12'h50C, "R3 via clear offset");

    // R4 R5
    do_write(12'h514, 32'h8000_0001, "R4", "R5");
    do_write(12'h518, 32'h0000_0030, "R4", "R5");
    do_read(12'h51C, "R4 readback");
    do_read(12'h700, "R5 cfg0");

    // R6: whole word stored, bit 0 mirrors into direction
    do_write(12'h714, 32'h0003_0704, "R6", "R6");
    do_read(12'h514, "R6 dir bit5 cleared");
    do_write(12'h77C, 32'hFFFF_FFFE, "R6", "R6");
    do_read(12'h77C, "R6 cfg31");
    do_write(12'h51C, 32'h8000_0000, "R4", "R5");
    do_write(12'h518, 32'h8000_0000, "R4", "R5");
    do_read(12'h77C, "R5 cfg31 upper kept");

    // R9 R10 boundaries
    do_read(12'h780, "R9 past last cfg");
    do_read(12'h702, "R9 misaligned");
    do_read(12'h500, "R9 below map");
    do_write(12'h510, 32'hFFFF_FFFF, "R10", "R10");
    do_write(12'h780, 32'hFFFF_FFFF, "R10", "R10");
    do_write(12'h505, 32'hFFFF_FFFF, "R10", "R10");

    // R8: input sampling
    pin_in = 32'h1234_ABCD; m_in = pin_in;
    do_read(12'h510, "R8");
    pin_in = 32'hFEDC_0001; m_in = pin_in;
    do_read(12'h510, "R8");

    // Random mix
    for (int i = 0; i < 500; i++) begin
      int k = $urandom_range(0, 10);
      logic [11:0] a = pick_addr(k);
      logic [31:0] d = $urandom;
      if ($urandom_range(0, 1) == 0) begin
        if (k == 3) begin pin_in = $urandom; m_in = pin_in; end
        do_read(a, (k < 3) ? "R3" : (k == 3) ? "R8" : (k < 7) ? "R4" : (k < 9) ? "R6" : "R9");
      end else begin
        do_write(a, d, (k < 3) ? "R2" : (k == 3) ? "R10" : (k < 7) ? "R4" : (k < 9) ? "R6" : "R10",
                 (k > 3 && k < 7) ? "R5" : "R6");
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule